// File: doc/BRIEF.md
# Amplitude-Variance Talk Detector

This block decides, once per audio frame, whether a telephone sample stream carries a talker. For every accepted signed PCM sample it takes the magnitude and feeds it into two exponentially smoothed estimates: a mean, and a variance around that mean. A power-of-two shift sets how fast both estimates move. Because the statistic is the spread of the magnitude rather than its level, a loud steady tone gives a low score, while the ragged envelope of speech gives a high one. At the end of each frame (80 samples by default, which is 10 ms at 8 kHz) the smoothed variance is compared against an onset threshold and a lower offset threshold.

A four-state machine turns these per-frame comparisons into decisions. A state change counts only after a run of consecutive qualifying frames, so a short burst of energy falls back without effect. The block has two roles. In the barge-in role it reports the first confirmed onset of speech with a pulse, then switches itself to the end-of-utterance role. In that role it reports each confirmed end of speech. The role is loaded from a mode input on a synchronous clear, and that clear also reloads the variance with a programmable noise floor. The thresholds, durations, smoothing shift and floor are run-time configuration inputs.

Top module: `talk_detect`

## Requirements
- R1: For each accepted sample, with a = |sample| (the most negative code counts as the largest positive magnitude) and k = cfg_shift, the mean updates as m += (a - m) >>> k and the variance as v += ((a - m_old)^2 - v) >>> k, where >>> is a flooring arithmetic shift. A tone of constant magnitude, however loud, never starts an onset. A larger k makes an earlier variance persist longer.
- R2: A decision is taken only once per FRAME_LEN accepted samples, in the cycle after the last sample of the frame is accepted. state_o changes only at such a decision or at clear. state_o encodes 0 = silence, 1 = onset pending, 2 = speech, 3 = offset pending.
- R3: A frame counts as loud when the variance is strictly greater than cfg_on_thr. From silence, a loud frame enters onset pending. cfg_on_frames consecutive loud frames confirm speech. A frame that is not loud during onset pending returns the state to silence with no pulse.
- R4: A frame counts as quiet when the variance is strictly less than cfg_off_thr. From speech, a quiet frame enters offset pending. A frame that is not quiet during offset pending returns the state to speech with no pulse.
- R5: cfg_off_frames consecutive quiet frames confirm the end of the utterance. utt_end is then high for exactly one cycle, and state_o returns to 0 in that same cycle.
- R6: speech_start is high for exactly one cycle, with state_o = 2, when speech is confirmed in the barge-in role. That confirmation switches the block to the end-of-utterance role, and later onsets in that role raise no pulse.
- R7: The role is loaded from mode_eou (0 = barge-in, 1 = end-of-utterance) only on clear, and is barge-in after reset. mode_eou has no effect at any other time.
- R8: Clear sets the mean to 0, the variance to cfg_floor, the frame position to 0, the state to silence and the pending count to 0, and raises no pulse. When clear falls in the same cycle as a frame decision, clear wins.
- R9: After reset, state_o is 0 and both pulse outputs are low.
- R10: A cfg_on_frames or cfg_off_frames value of 0 or 1 confirms the transition on the first qualifying frame, with no pending state in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart: statistics to floor, role from mode_eou |
| mode_eou | input | 1 | Role loaded at clear: 0 barge-in, 1 end-of-utterance |
| sample_vld | input | 1 | Sample strobe |
| sample | input | SAMPLE_W | Signed PCM sample |
| cfg_shift | input | SHIFT_W | Smoothing shift k |
| cfg_floor | input | STAT_W | Variance value loaded at clear |
| cfg_on_thr | input | STAT_W | Loud-frame threshold |
| cfg_off_thr | input | STAT_W | Quiet-frame threshold |
| cfg_on_frames | input | DUR_W | Loud frames needed to confirm speech |
| cfg_off_frames | input | DUR_W | Quiet frames needed to confirm end |
| speech_start | output | 1 | One-cycle pulse on a confirmed barge-in onset |
| utt_end | output | 1 | One-cycle pulse on a confirmed end of utterance |
| state_o | output | 2 | Current detector state |

## Verification
Two functions can fall in the same cycle: the synchronous clear and the frame decision that would confirm speech. The bench builds two loud frames of onset pending, sends a third loud frame, and raises clear in exactly the cycle after that frame's last sample, which is when the decision is taken. It judges that clear won in two ways: state_o must read silence with no speech_start, and a following loud frame must land only in onset pending. That second reading shows that both the pending count and the statistics restarted.

// File: rtl/talk_detect_pkg.sv
package talk_detect_pkg;

  // Width of the signed working arithmetic for the smoothing filters.
  localparam int ARITH_W = 48;
  localparam int KSH_W   = 8;

  typedef enum logic [1:0] {
    ST_SILENCE = 2'd0,
    ST_ONSET   = 2'd1,
    ST_SPEECH  = 2'd2,
    ST_OFFSET  = 2'd3
  } tdet_state_e;

  // One exponential smoothing step: move cur toward tgt by (tgt-cur)/2^k,
  // the division being a flooring arithmetic shift.
  function automatic logic signed [ARITH_W-1:0] ema_step(
    input logic signed [ARITH_W-1:0] cur,
    input logic signed [ARITH_W-1:0] tgt,
    input logic        [KSH_W-1:0]   k
  );
    logic signed [ARITH_W-1:0] gap;
    gap = tgt - cur;
    return cur + (gap >>> k);
  endfunction

  // Square of a deviation, kept in the working width.
  function automatic logic signed [ARITH_W-1:0] sq_dev(
    input logic signed [ARITH_W-1:0] d
  );
    return d * d;
  endfunction

endpackage

// File: rtl/talk_detect_stats.sv
module talk_detect_stats
  import talk_detect_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int STAT_W   = 32,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       sample_vld,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [SHIFT_W-1:0]  cfg_shift,
  input  logic        [STAT_W-1:0]   cfg_floor,
  output logic        [STAT_W-1:0]   var_o
);

  localparam int PAD_S = ARITH_W - SAMPLE_W;
  localparam int PAD_V = ARITH_W - STAT_W;
  localparam int PAD_K = KSH_W - SHIFT_W;

  logic [SAMPLE_W-1:0]       mag;
  logic [SAMPLE_W-1:0]       mean_q;
  logic [STAT_W-1:0]         var_q;
  logic signed [ARITH_W-1:0] mag_w, mean_w, var_w, dev_w, dev_sq;
  logic [KSH_W-1:0]          k_w;

  // Magnitude with saturation of the most negative code.
  always_comb begin
    if (sample[SAMPLE_W-1]) begin
      if (sample == {1'b1, {(SAMPLE_W-1){1'b0}}})
        mag = {1'b0, {(SAMPLE_W-1){1'b1}}};
      else
        mag = -sample;
    end else begin
      mag = sample;
    end
  end

  assign mag_w  = $signed({{PAD_S{1'b0}}, mag});
  assign mean_w = $signed({{PAD_S{1'b0}}, mean_q});
  assign var_w  = $signed({{PAD_V{1'b0}}, var_q});
  assign k_w    = {{PAD_K{1'b0}}, cfg_shift};
  assign dev_w  = mag_w - mean_w;
  assign dev_sq = sq_dev(dev_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mean_q <= '0;
      var_q  <= '0;
    end else if (clear) begin
      mean_q <= '0;
      var_q  <= cfg_floor;
    end else if (sample_vld) begin
      mean_q <= SAMPLE_W'(ema_step(mean_w, mag_w, k_w));
      var_q  <= STAT_W'(ema_step(var_w, dev_sq, k_w));
    end
  end

  assign var_o = var_q;

  AST_CLEAR_LOADS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (var_q == $past(cfg_floor))) else $error("floor not loaded"); // R8
  AST_IDLE_HOLDS_STATS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !clear) |=> ($stable(var_q) && $stable(mean_q))) else $error("stats moved"); // R1

endmodule

// File: rtl/talk_detect_framer.sv
module talk_detect_framer #(
  parameter int FRAME_LEN = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample_vld,
  output logic frame_tick
);

  localparam int CNT_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] pos_q;
  logic             frame_last;
  logic             tick_q;

  assign frame_last = sample_vld && (pos_q == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      tick_q <= 1'b0;
    end else if (clear) begin
      pos_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= frame_last;
      if (sample_vld) pos_q <= frame_last ? '0 : pos_q + 1'b1;
    end
  end

  assign frame_tick = tick_q;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q) else $error("back-to-back frame ticks"); // R2
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS) else $error("frame position out of range"); // R2

endmodule

// File: rtl/talk_detect_fsm.sv
module talk_detect_fsm
  import talk_detect_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             mode_eou,
  input  logic             frame_tick,
  input  logic             loud,
  input  logic             quiet,
  input  logic [DUR_W-1:0] cfg_on_frames,
  input  logic [DUR_W-1:0] cfg_off_frames,
  output logic [1:0]       state_o,
  output logic             speech_start,
  output logic             utt_end
);

  localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

  tdet_state_e      state_q, state_d;
  logic [DUR_W-1:0] run_q, run_d, run_inc;
  logic             role_eou_q, role_eou_d;
  logic             start_q, end_q, start_d, end_d;
  logic             confirm_on, confirm_off;

  assign run_inc = run_q + 1'b1;

  always_comb begin
    state_d     = state_q;
    run_d       = run_q;
    role_eou_d  = role_eou_q;
    start_d     = 1'b0;
    end_d       = 1'b0;
    confirm_on  = 1'b0;
    confirm_off = 1'b0;
    if (frame_tick) begin
      unique case (state_q)
        ST_SILENCE: begin
          if (loud) begin
            if (cfg_on_frames <= ONE) confirm_on = 1'b1;
            else begin
              state_d = ST_ONSET;
              run_d   = ONE;
            end
          end
        end
        ST_ONSET: begin
          if (!loud) begin
            state_d = ST_SILENCE;
            run_d   = '0;
          end else if (run_inc >= cfg_on_frames) confirm_on = 1'b1;
          else run_d = run_inc;
        end
        ST_SPEECH: begin
          if (quiet) begin
            if (cfg_off_frames <= ONE) confirm_off = 1'b1;
            else begin
              state_d = ST_OFFSET;
              run_d   = ONE;
            end
          end
        end
        ST_OFFSET: begin
          if (!quiet) begin
            state_d = ST_SPEECH;
            run_d   = '0;
          end else if (run_inc >= cfg_off_frames) confirm_off = 1'b1;
          else run_d = run_inc;
        end
      endcase
    end
    if (confirm_on) begin
      state_d    = ST_SPEECH;
      run_d      = '0;
      role_eou_d = 1'b1;
      start_d    = !role_eou_q;
    end
    if (confirm_off) begin
      state_d = ST_SILENCE;
      run_d   = '0;
      end_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_SILENCE;
      run_q      <= '0;
      role_eou_q <= 1'b0;
      start_q    <= 1'b0;
      end_q      <= 1'b0;
    end else if (clear) begin
      state_q    <= ST_SILENCE;
      run_q      <= '0;
      role_eou_q <= mode_eou;
      start_q    <= 1'b0;
      end_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      run_q      <= run_d;
      role_eou_q <= role_eou_d;
      start_q    <= start_d;
      end_q      <= end_d;
    end
  end

  assign state_o      = state_q;
  assign speech_start = start_q;
  assign utt_end      = end_q;

  AST_STATE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !clear) |=> $stable(state_q)) else $error("state moved off a frame"); // R2
  AST_START_IN_SPEECH: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (state_q == ST_SPEECH)) else $error("start pulse outside speech"); // R6
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q) else $error("start pulse too long"); // R6
  AST_NO_START_IN_EOU: assert property (@(posedge clk) disable iff (!rst_n)
    (role_eou_q && !clear) |=> !start_q) else $error("start pulse in end role"); // R6
  AST_END_TO_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> (state_q == ST_SILENCE)) else $error("end pulse outside silence"); // R5
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q) else $error("end pulse too long"); // R5
  AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (role_eou_q && !clear) |=> role_eou_q) else $error("role dropped without clear"); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state_q == ST_SILENCE && !start_q && !end_q)) else $error("clear lost"); // R8

endmodule

// File: rtl/talk_detect.sv
module talk_detect #(
  parameter int SAMPLE_W  = 16,
  parameter int STAT_W    = 32,
  parameter int SHIFT_W   = 4,
  parameter int DUR_W     = 8,
  parameter int FRAME_LEN = 80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       mode_eou,
  input  logic                       sample_vld,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [SHIFT_W-1:0]  cfg_shift,
  input  logic        [STAT_W-1:0]   cfg_floor,
  input  logic        [STAT_W-1:0]   cfg_on_thr,
  input  logic        [STAT_W-1:0]   cfg_off_thr,
  input  logic        [DUR_W-1:0]    cfg_on_frames,
  input  logic        [DUR_W-1:0]    cfg_off_frames,
  output logic                       speech_start,
  output logic                       utt_end,
  output logic        [1:0]          state_o
);

  logic [STAT_W-1:0] frame_var;
  logic              frame_tick;
  logic              loud, quiet;

  talk_detect_stats #(
    .SAMPLE_W(SAMPLE_W), .STAT_W(STAT_W), .SHIFT_W(SHIFT_W)
  ) u_stats (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample_vld(sample_vld),
    .sample(sample), .cfg_shift(cfg_shift), .cfg_floor(cfg_floor),
    .var_o(frame_var)
  );

  talk_detect_framer #(.FRAME_LEN(FRAME_LEN)) u_framer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample_vld(sample_vld),
    .frame_tick(frame_tick)
  );

  // Per-frame classification with hysteresis between the two thresholds.
  assign loud  = frame_var > cfg_on_thr;
  assign quiet = frame_var < cfg_off_thr;

  talk_detect_fsm #(.DUR_W(DUR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode_eou(mode_eou),
    .frame_tick(frame_tick), .loud(loud), .quiet(quiet),
    .cfg_on_frames(cfg_on_frames), .cfg_off_frames(cfg_off_frames),
    .state_o(state_o), .speech_start(speech_start), .utt_end(utt_end)
  );

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(speech_start && utt_end)) else $error("both pulses at once"); // R5

endmodule

// File: tb/test_talk_detect.sv
`timescale 1ns/1ps
module test_talk_detect;

  localparam int FLEN = 80;
  localparam logic [1:0] KQ = 2'd0; // quiet: magnitude 10, alternating sign
  localparam logic [1:0] KL = 2'd1; // speech-like: magnitude 0 / 8000 alternating
  localparam logic [1:0] KT = 2'd2; // steady tone: magnitude 8000 every sample

  // {req[3:0], exp_end, exp_start, exp_state[1:0], kind[1:0]}
  localparam logic [9:0] VEC [16] = '{
    {4'd2, 1'b0, 1'b0, 2'd0, KQ},
    {4'd3, 1'b0, 1'b0, 2'd1, KL},
    {4'd3, 1'b0, 1'b0, 2'd0, KQ},
    {4'd1, 1'b0, 1'b0, 2'd0, KT},
    {4'd3, 1'b0, 1'b0, 2'd1, KL},
    {4'd3, 1'b0, 1'b0, 2'd1, KL},
    {4'd6, 1'b0, 1'b1, 2'd2, KL},
    {4'd4, 1'b0, 1'b0, 2'd3, KQ},
    {4'd4, 1'b0, 1'b0, 2'd2, KL},
    {4'd4, 1'b0, 1'b0, 2'd3, KQ},
    {4'd5, 1'b1, 1'b0, 2'd0, KQ},
    {4'd3, 1'b0, 1'b0, 2'd1, KL},
    {4'd3, 1'b0, 1'b0, 2'd1, KL},
    {4'd6, 1'b0, 1'b0, 2'd2, KL},
    {4'd4, 1'b0, 1'b0, 2'd3, KQ},
    {4'd5, 1'b1, 1'b0, 2'd0, KQ}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic mode_eou = 1'b0;
  logic sample_vld = 1'b0;
  logic signed [15:0] sample = '0;
  logic [3:0]  cfg_shift = 4'd2;
  logic [31:0] cfg_floor = 32'd0;
  logic [31:0] cfg_on_thr = 32'd1_000_000;
  logic [31:0] cfg_off_thr = 32'd100_000;
  logic [7:0]  cfg_on_frames = 8'd3;
  logic [7:0]  cfg_off_frames = 8'd2;
  logic speech_start, utt_end;
  logic [1:0] state_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  talk_detect i_talk_detect (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode_eou(mode_eou),
    .sample_vld(sample_vld), .sample(sample), .cfg_shift(cfg_shift),
    .cfg_floor(cfg_floor), .cfg_on_thr(cfg_on_thr), .cfg_off_thr(cfg_off_thr),
    .cfg_on_frames(cfg_on_frames), .cfg_off_frames(cfg_off_frames),
    .speech_start(speech_start), .utt_end(utt_end), .state_o(state_o)
  );

  function automatic logic signed [15:0] pattern(input logic [1:0] kind, input int i);
    case (kind)
      KQ:      return (i % 2 == 1) ? -16'sd10 : 16'sd10;
      KL:      return (i % 2 == 0) ? 16'sd0 : ((i % 4 == 1) ? 16'sd8000 : -16'sd8000);
      default: return (i % 2 == 1) ? -16'sd8000 : 16'sd8000;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] st, input logic s, input logic e);
    n_vec++;
    if (state_o !== st || speech_start !== s || utt_end !== e) begin
      n_bad++;
      $display("FAIL %s: state=%0d start=%0b end=%0b, expected state=%0d start=%0b end=%0b",
               req, state_o, speech_start, utt_end, st, s, e);
    end
  endtask

  task automatic send_samples(input logic [1:0] kind, input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk);
      sample_vld = 1'b1;
      sample = pattern(kind, i);
    end
  endtask

  // Ends between the edge that takes the last sample and the decision edge.
  task automatic end_samples();
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  // Sends a frame and returns after the decision edge.
  task automatic frame(input logic [1:0] kind);
    send_samples(kind, 0, FLEN);
    end_samples();
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset state", 2'd0, 1'b0, 1'b0);

    // Vector table: one frame per entry, checked after its decision edge.
    for (int v = 0; v < 16; v++) begin
      frame(VEC[v][1:0]);
      check($sformatf("R%0d vector %0d", VEC[v][9:6], v), VEC[v][3:2], VEC[v][4], VEC[v][5]);
    end

    // R8 / R1: clear loads the floor; a slow shift keeps it above the onset threshold.
    cfg_floor = 32'd50_000_000;
    cfg_shift = 4'd15;
    pulse_clear();
    frame(KQ);
    check("R8 floor persists with slow shift", 2'd1, 1'b0, 1'b0);
    cfg_shift = 4'd2;
    pulse_clear();
    frame(KQ);
    check("R1 fast shift washes floor out", 2'd0, 1'b0, 1'b0);

    // R8: clear in the decision cycle that would confirm speech.
    cfg_floor = 32'd0;
    pulse_clear();
    frame(KL);
    check("R3 onset pending 1", 2'd1, 1'b0, 1'b0);
    frame(KL);
    check("R3 onset pending 2", 2'd1, 1'b0, 1'b0);
    send_samples(KL, 0, FLEN);
    end_samples();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R8 clear beats decision", 2'd0, 1'b0, 1'b0);
    frame(KL);
    check("R8 count restarted after clear", 2'd1, 1'b0, 1'b0);

    // R7: end-of-utterance role loaded at clear; later mode changes ignored.
    mode_eou = 1'b1;
    pulse_clear();
    mode_eou = 1'b0;
    frame(KL);
    frame(KL);
    frame(KL);
    check("R7 onset in end role gives no start", 2'd2, 1'b0, 1'b0);
    frame(KQ);
    check("R4 offset pending", 2'd3, 1'b0, 1'b0);
    frame(KQ);
    check("R5 end of utterance in end role", 2'd0, 1'b0, 1'b1);
    frame(KL);
    frame(KL);
    frame(KL);
    check("R7 mode change without clear ignored", 2'd2, 1'b0, 1'b0);

    // R10: single-frame durations confirm directly.
    cfg_on_frames = 8'd1;
    cfg_off_frames = 8'd1;
    pulse_clear();
    frame(KL);
    check("R10 onset on first loud frame", 2'd2, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 start pulse lasts one cycle", 2'd2, 1'b0, 1'b0);
    frame(KQ);
    check("R10 end on first quiet frame", 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    check("R5 end pulse lasts one cycle", 2'd0, 1'b0, 1'b0);

    // R2: no decision in the middle of a frame.
    send_samples(KL, 0, FLEN / 2);
    @(negedge clk);
    check("R2 no change mid-frame", 2'd0, 1'b0, 1'b0);
    send_samples(KL, FLEN / 2, FLEN);
    end_samples();
    @(negedge clk);
    check("R6 second onset after role switch", 2'd2, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule